// File: doc/BRIEF.md
# Microsecond Synchronization Timer with Two-Word Staged Reload

This block keeps a free-running microsecond counter that is twice the bus word wide. With the default word width of 32 bits the counter is 64 bits wide. The counter advances once for every cycle in which the tick-enable input is high. That input comes from a microsecond tick generator outside the block. The full count is also driven out in parallel, so that other logic, such as receive timestamping, can sample it.

Software loads a new time in two steps. It first writes a low load word, which only stages the value. It then writes the high load word. The top bit of the high load word is a strobe, and the remaining bits carry the upper part of the value. The counter takes the new value only when the strobe bit goes from 1 to 0. In practice this means one write of the high word with the strobe set, followed by a second write with the strobe clear.

Software reads the count one word at a time. A read of the low word captures the upper half of the same count in a shadow register. A following read of the high word returns that captured half, so a low read and the high read after it always describe one instant.

Top module: `tsf_timer`

## Requirements
- R1: After a synchronous active-low reset, the count is zero, the staged low word and the staged strobe are zero, the shadow is zero, and the read data is zero.
- R2: In each cycle with tick_en high and no load, the count rises by exactly one. In each cycle with tick_en low and no load, the count holds its value.
- R3: Counting on from the all-ones value gives zero on the next tick.
- R4: A write with wr_sel=0 stores the low load word and has no effect on the count.
- R5: A write with wr_sel=1 triggers no load in two cases: when bit WORD_W-1 of wr_data is 1, and when the strobe bit stored by the previous high write is 0.
- R6: When a write with wr_sel=1 carries bit WORD_W-1 equal to 0 and the strobe bit stored by the previous high write is 1, the count after that clock edge equals {0, wr_data[WORD_W-2:0], staged low word}.
- R7: If tick_en is high in the same cycle as a load, the count takes the load value without adding one.
- R8: A read with rd_sel=0 puts the lower half of the count, as it was just before that edge, on rd_data in the next cycle. The same edge captures the upper half of that count into the shadow.
- R9: A read with rd_sel=1 puts the shadow value on rd_data in the next cycle, not the live upper half. rd_data keeps its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-microsecond advance enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 low load word, 1 high load word with strobe in the top bit |
| wr_data | input | WORD_W | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | Read target: 0 live low word (captures the shadow), 1 shadow high word |
| rd_data | output | WORD_W | Read data, valid the cycle after rd_en |
| count_o | output | 2*WORD_W | Running count |

## Verification
The bench builds the block with WORD_W=8, which gives a 16-bit counter. At that size every 7-bit upper load value can be paired with several low words, and each pairing can be loaded and read back. A single run of about 33 thousand ticks also reaches the all-ones value and the wrap to zero. The bench models the staged strobe, the shadow and the count arithmetically, and compares the count after every cycle. This exposes spurious loads caused by a rising strobe or by a repeated clear, and it shows any increment lost during a load.

// File: rtl/tsf_pkg.sv
// Shared types of the microsecond synchronization timer.
// Assumes single-bit word selection on both the write and read paths.
package tsf_pkg;
    typedef enum logic {
        SEL_LO = 1'b0,
        SEL_HI = 1'b1
    } word_sel_e;
endpackage

// File: rtl/tsf_load_stage.sv
// Staging of the two-word load value and detection of the strobe clear.
// Assumes one register write per cycle. A load is issued in the same cycle
// as the high write that clears a previously set strobe.
module tsf_load_stage
    import tsf_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int CNT_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  word_sel_e         wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    output logic              load_o,
    output logic [CNT_W-1:0]  load_val_o
);
    localparam int MSB = WORD_W - 1;

    logic [WORD_W-1:0] lo_q;
    logic              strobe_q;
    logic              hi_wr;
    logic              lo_wr;

    // Decode which staging register this cycle's write targets
    always_comb begin
        hi_wr = wr_en && (wr_sel == SEL_HI);
        lo_wr = wr_en && (wr_sel == SEL_LO);
    end

    // Hold the staged low word and the last written strobe bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q     <= '0;
            strobe_q <= 1'b0;
        end else begin
            if (lo_wr) lo_q <= wr_data;
            if (hi_wr) strobe_q <= wr_data[MSB];
        end
    end

    // Issue a load when a high write clears a set strobe
    always_comb begin
        load_o     = hi_wr && strobe_q && !wr_data[MSB];
        load_val_o = {1'b0, wr_data[MSB-1:0], lo_q};
    end

    // R4
    lo_write_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr |-> !load_o);

    // R5
    strobe_set_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_wr && wr_data[MSB]) |-> !load_o);

    // R5
    strobe_idle_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_wr && !strobe_q) |-> !load_o);
endmodule

// File: rtl/tsf_counter.sv
// Free-running count register with a load that takes priority over the tick.
// Assumes load_i is a single-cycle pulse. The count wraps modulo 2**CNT_W.
module tsf_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q;

    // Advance, reload, or hold the count
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load_i) cnt_q <= load_val_i;
        else if (tick_i) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(cnt_q));

    // R6 R7
    load_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/tsf_read_port.sv
// Word-wise read of the count, using a shadow for a consistent upper half.
// Assumes one read per cycle. rd_data_o is registered and holds between reads.
module tsf_read_port
    import tsf_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int CNT_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  word_sel_e         rd_sel,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [WORD_W-1:0] rd_data_o
);
    logic [WORD_W-1:0] shadow_q;
    logic [WORD_W-1:0] rd_q;

    // Return the low half and capture the upper half, or return the shadow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            rd_q     <= '0;
        end else if (rd_en) begin
            if (rd_sel == SEL_LO) begin
                rd_q     <= cnt_i[WORD_W-1:0];
                shadow_q <= cnt_i[CNT_W-1:WORD_W];
            end else begin
                rd_q <= shadow_q;
            end
        end
    end

    assign rd_data_o = rd_q;

    // R8
    lo_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == SEL_LO) |=> (rd_q == $past(cnt_i[WORD_W-1:0])));

    // R9
    hi_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == SEL_HI) |=> (rd_q == $past(shadow_q)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_q));
endmodule

// File: rtl/tsf_timer.sv
// Top level of the microsecond synchronization timer.
// Joins the load staging, the count register and the read port.
// Assumes tick_en is already a one-cycle-per-microsecond enable.
module tsf_timer
    import tsf_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int CNT_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              rd_sel,
    output logic [WORD_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count_o
);
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cnt;

    tsf_load_stage #(.WORD_W(WORD_W)) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (word_sel_e'(wr_sel)),
        .wr_data    (wr_data),
        .load_o     (load),
        .load_val_o (load_val)
    );

    tsf_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_en),
        .load_i     (load),
        .load_val_i (load_val),
        .cnt_o      (cnt)
    );

    tsf_read_port #(.WORD_W(WORD_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_sel    (word_sel_e'(rd_sel)),
        .cnt_i     (cnt),
        .rd_data_o (rd_data)
    );

    assign count_o = cnt;

    // R3
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !load && (&cnt)) |=> (count_o == '0));
endmodule

// File: tb/test_tsf_timer.sv
module test_tsf_timer;
    localparam int W = 8;
    localparam int C = 2 * W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b0;
    logic         wr_en = 1'b0;
    logic         wr_sel = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_en = 1'b0;
    logic         rd_sel = 1'b0;
    logic [W-1:0] rd_data;
    logic [C-1:0] count_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [C-1:0] m_cnt = '0;
    logic [W-1:0] m_lo = '0;
    logic         m_strobe = 1'b0;
    logic [W-1:0] m_shadow = '0;
    logic [W-1:0] m_rd = '0;

    tsf_timer #(.WORD_W(W)) i_tsf_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_data(rd_data), .count_o(count_o)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [C-1:0] act, input logic [C-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, model the edge, compare at the next negedge
    task automatic step(input logic tk, input logic we, input logic ws, input logic [W-1:0] wd,
                        input logic re, input logic rs, input string req);
        logic ld;
        tick_en = tk; wr_en = we; wr_sel = ws; wr_data = wd; rd_en = re; rd_sel = rs;
        ld = we && ws && m_strobe && !wd[W-1];
        if (re) begin
            if (!rs) begin
                m_rd = m_cnt[W-1:0];
                m_shadow = m_cnt[C-1:W];
            end else begin
                m_rd = m_shadow;
            end
        end
        if (ld)      m_cnt = {1'b0, wd[W-2:0], m_lo};
        else if (tk) m_cnt = m_cnt + 1'b1;
        if (we && !ws) m_lo = wd;
        if (we && ws)  m_strobe = wd[W-1];
        @(posedge clk);
        @(negedge clk);
        tick_en = 0; wr_en = 0; rd_en = 0;
        check(req, count_o, m_cnt);
        if (re) check(req, {{W{1'b0}}, rd_data}, {{W{1'b0}}, m_rd});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R2 watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", count_o, '0);
        check("R1", {{W{1'b0}}, rd_data}, '0);
        step(0, 0, 0, 0, 1, 1, "R1");
        step(0, 0, 0, 0, 1, 0, "R1");

        // R2 counting and holding
        for (int k = 0; k < 20; k++) step(k % 3 != 0, 0, 0, 0, 0, 0, "R2");

        // R4 low write alone leaves the count alone
        step(1, 1, 0, 8'hA5, 0, 0, "R4");
        step(0, 1, 0, 8'h3C, 0, 0, "R4");

        // R5 clear without prior set, then repeated set, then repeated clear
        step(1, 1, 1, 8'h12, 0, 0, "R5");
        step(1, 1, 1, 8'h92, 0, 0, "R5");
        step(1, 1, 1, 8'hFF, 0, 0, "R5");
        step(1, 1, 1, 8'h21, 0, 0, "R6");
        check("R6", count_o, {1'b0, 7'h21, 8'h3C});
        step(1, 1, 1, 8'h05, 0, 0, "R5");

        // R7 load with tick in the same cycle
        step(0, 1, 1, 8'h80, 0, 0, "R7");
        step(1, 1, 1, 8'h44, 0, 0, "R7");
        check("R7", count_o, {1'b0, 7'h44, 8'h3C});

        // R6 R8 R9 sweep over every upper value and several low values
        for (int h = 0; h < 128; h++) begin
            for (int v = 0; v < 4; v++) begin
                logic [W-1:0] lo;
                lo = (v == 0) ? 8'h00 : (v == 1) ? 8'h55 : (v == 2) ? 8'hFF : 8'(h * 2 + 1);
                step((h + v) % 3 != 0, 1, 0, lo, 0, 0, "R4");
                step((h + v) % 2 == 0, 1, 1, 8'h80 | 8'(h), 0, 0, "R5");
                step((h + v) % 3 == 1, 1, 1, 8'(h), 0, 0, "R6");
                step(1, 0, 0, 0, 1, 0, "R8");
                step(1, 0, 0, 0, 0, 0, "R9");
                step(v % 2 == 0, 0, 0, 0, 1, 1, "R9");
            end
        end

        // R3 wrap: load 0x7FFF and tick past all-ones
        step(0, 1, 0, 8'hFF, 0, 0, "R4");
        step(0, 1, 1, 8'hFF, 0, 0, "R5");
        step(0, 1, 1, 8'h7F, 0, 0, "R6");
        for (int k = 0; k < 32768; k++) step(1, 0, 0, 0, 0, 0, "R3");
        check("R3", count_o, 16'hFFFF);
        step(1, 0, 0, 0, 0, 0, "R3");
        check("R3", count_o, 16'h0000);
        step(1, 0, 0, 0, 1, 0, "R8");
        step(0, 0, 0, 0, 1, 1, "R9");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule